// File: doc/BRIEF.md
# Multi-Sample Strip Hit Filter

This block reduces a streaming detector readout. Each input record is one strip: an identifier and six consecutive time samples. A common-mode baseline is tracked as a running average and subtracted from every sample. Pulse-shape cuts then decide whether the strip holds a genuine hit. Only strips that pass leave the block, carrying their baseline-corrected samples. Everything else is dropped, which typically cuts the data volume by about a factor of three.

Records enter and leave through valid/ready handshakes. Output order matches input order. The last record of each event carries a flag. When an event's final strip is dropped, an empty marker record closes the event instead. The threshold is a quasi-static configuration input.

Top module: `strip_hit_filter`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high and the baseline equals `INIT_BASE` (default 100) with zero fraction.
- R2: An emitted sample k sits in `out_samples[13k+12:13k]` as a 13-bit two's complement value equal to the raw sample minus the integer part of the baseline held when the strip was accepted.
- R3: The peak is the largest corrected sample, and the earliest index wins a tie. A strip whose peak is at index 0 or index 5 is dropped.
- R4: A strip whose peak corrected value is below `cfg_thresh` (compared as a signed value) is dropped. A peak equal to the threshold passes.
- R5: The baseline keeps 4 fraction bits. It changes only when a below-threshold strip is accepted, and then by B += ((m*16) - B) >>> 4, where m = floor((s0+s1+s2+s3)/4).
- R6: Only strips that pass the cuts are emitted, in their input order.
- R7: `out_last` marks the record that closes an event. If the event's last strip is dropped, the block emits a marker with `out_empty`=1, `out_last`=1 and all data fields zero.
- R8: `in_ready` = !`out_valid` || `out_ready`. While the output is stalled, all of its fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh | input | 12 | Minimum peak corrected amplitude |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted when high with in_valid |
| in_strip | input | 10 | Strip identifier |
| in_samples | input | 72 | Six 12-bit unsigned samples, sample k at [12k+11:12k] |
| in_last | input | 1 | Last strip of the event |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream ready |
| out_strip | output | 10 | Strip identifier, zero on a marker |
| out_samples | output | 78 | Six 13-bit corrected samples |
| out_last | output | 1 | Record closes the event |
| out_empty | output | 1 | Record is an end-of-event marker |

## Verification
The bound checker watches several rules on every cycle. It confirms that output fields freeze during a stall and that no input is taken while the output is blocked. It confirms that markers are always flagged last and zero-filled, that no emitted strip peaks at the first or sixth sample, and that the baseline moves only on an accepted record. Some behaviour only the bench's scenarios can show. This covers the exact corrected values and the earliest-wins tie rule. It also covers the inclusive threshold boundary, the baseline converging over a run of quiet strips, and the preserved order under random backpressure. All of these are compared against a behavioural model every clock.

// File: rtl/strip_hit_filter.sv
module strip_hit_filter #(
  parameter int SW = 12,
  parameter int IDW = 10,
  parameter int FRAC = 4,
  parameter int INIT_BASE = 100,
  localparam int NS = 6,
  localparam int CW = SW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     cfg_thresh,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDW-1:0]    in_strip,
  input  logic [NS*SW-1:0]  in_samples,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDW-1:0]    out_strip,
  output logic [NS*CW-1:0]  out_samples,
  output logic              out_last,
  output logic              out_empty
);
  localparam int BW = SW + FRAC;

  logic [BW-1:0] base_q;
  logic [SW-1:0] base_int;
  logic signed [CW-1:0] corr [NS];
  logic [NS*CW-1:0] corr_flat;
  logic signed [CW-1:0] pval;
  logic [2:0] pidx;
  logic below, keep, accept, emit;
  logic [SW+1:0] sum4;
  logic [SW-1:0] mean4;
  logic signed [BW:0] diff, base_sum;

  assign base_int = base_q[BW-1:FRAC];

  for (genvar k = 0; k < NS; k++) begin : g_corr
    assign corr[k] = $signed({1'b0, in_samples[k*SW +: SW]}) - $signed({1'b0, base_int});
    assign corr_flat[k*CW +: CW] = corr[k];
  end

  always_comb begin
    pval = corr[0];
    pidx = '0;
    for (int k = 1; k < NS; k++) begin
      if (corr[k] > pval) begin
        pval = corr[k];
        pidx = 3'(k);
      end
    end
  end

  assign below  = pval < $signed({1'b0, cfg_thresh});
  assign keep   = !below && (pidx != 3'd0) && (pidx != 3'(NS-1));
  assign in_ready = !out_valid || out_ready;
  assign accept = in_valid && in_ready;
  assign emit   = accept && (keep || in_last);

  assign sum4  = (SW+2)'(in_samples[0*SW +: SW]) + (SW+2)'(in_samples[1*SW +: SW])
               + (SW+2)'(in_samples[2*SW +: SW]) + (SW+2)'(in_samples[3*SW +: SW]);
  assign mean4 = sum4[SW+1:2];
  assign diff  = $signed({1'b0, mean4, {FRAC{1'b0}}}) - $signed({1'b0, base_q});
  assign base_sum = $signed({1'b0, base_q}) + (diff >>> FRAC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= BW'(INIT_BASE) << FRAC;
    end else if (accept && below) begin
      base_q <= base_sum[BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_strip   <= '0;
      out_samples <= '0;
      out_last    <= 1'b0;
      out_empty   <= 1'b0;
    end else if (emit) begin
      out_valid   <= 1'b1;
      out_strip   <= keep ? in_strip : '0;
      out_samples <= keep ? corr_flat : '0;
      out_last    <= in_last;
      out_empty   <= !keep;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

module strip_hit_filter_chk #(
  parameter int SW = 12,
  parameter int IDW = 10,
  parameter int FRAC = 4,
  localparam int NS = 6,
  localparam int CW = SW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IDW-1:0]    out_strip,
  input logic [NS*CW-1:0]  out_samples,
  input logic              out_last,
  input logic              out_empty,
  input logic [SW+FRAC-1:0] base_q
);
  function automatic logic peak_inside(input logic [NS*CW-1:0] v);
    logic signed [CW-1:0] best;
    int at;
    best = v[CW-1:0];
    at = 0;
    for (int k = 1; k < NS; k++) begin
      if ($signed(v[k*CW +: CW]) > best) begin
        best = v[k*CW +: CW];
        at = k;
      end
    end
    return (at != 0) && (at != NS-1);
  endfunction

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_strip) && $stable(out_samples)
      && $stable(out_last) && $stable(out_empty)); // R8
  AST_NO_TAKE_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_MARKER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_empty |-> out_last); // R7
  AST_MARKER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_empty |-> out_strip == '0 && out_samples == '0); // R7
  AST_PEAK_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_empty |-> peak_inside(out_samples)); // R3
  AST_BASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(base_q)); // R5
endmodule

bind strip_hit_filter strip_hit_filter_chk #(.SW(SW), .IDW(IDW), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_strip(out_strip),
  .out_samples(out_samples), .out_last(out_last), .out_empty(out_empty), .base_q(base_q));

// File: tb/strip_hit_filter_tb.sv
module strip_hit_filter_tb;
  logic clk = 0, rst_n = 0;
  logic [11:0] cfg_thresh = 12'd100;
  logic in_valid = 0, in_last = 0, out_ready = 1;
  logic [9:0] in_strip = '0;
  logic [71:0] in_samples = '0;
  logic in_ready, out_valid, out_last, out_empty;
  logic [9:0] out_strip;
  logic [77:0] out_samples;

  strip_hit_filter u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int kept_cnt = 0, mark_cnt = 0;
  logic [77:0] last_samp;
  bit bp = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model
  int mB;
  bit m_valid, m_last, m_empty, m_rdy, m_keep;
  logic [9:0] m_strip;
  logic [77:0] m_samp;
  int q_ids[$];
  int c[6];
  int mbase, pv, pi, m4;

  always @(posedge clk) begin
    if (!rst_n) begin
      mB = 100 * 16; m_valid = 0; m_last = 0; m_empty = 0; m_strip = 0; m_samp = 0;
    end else begin
      m_rdy = !m_valid || out_ready;
      if (m_valid && out_ready) m_valid = 0;
      if (in_valid && m_rdy) begin
        mbase = mB / 16; pv = -100000; pi = 0;
        for (int k = 0; k < 6; k++) begin
          c[k] = int'(in_samples[k*12 +: 12]) - mbase;
          if (c[k] > pv) begin pv = c[k]; pi = k; end
        end
        m_keep = (pv >= int'(cfg_thresh)) && pi != 0 && pi != 5;
        if (m_keep || in_last) begin
          m_valid = 1; m_last = in_last; m_empty = !m_keep;
          m_strip = m_keep ? in_strip : 10'd0;
          for (int k = 0; k < 6; k++) m_samp[k*13 +: 13] = m_keep ? 13'(c[k]) : 13'd0;
          if (m_keep) q_ids.push_back(int'(in_strip));
        end
        if (pv < int'(cfg_thresh)) begin
          m4 = (int'(in_samples[0 +: 12]) + int'(in_samples[12 +: 12])
              + int'(in_samples[24 +: 12]) + int'(in_samples[36 +: 12])) / 4;
          mB = mB + ((m4 * 16 - mB) >>> 4);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == m_valid, "R6 valid vs model", out_valid, m_valid);
      chk(in_ready == (!m_valid || out_ready), "R8 ready rule", in_ready, !m_valid || out_ready);
      if (m_valid) begin
        chk(out_samples == m_samp, "R2 samples vs model", out_samples, m_samp);
        chk(out_strip == m_strip, "R6 strip vs model", out_strip, m_strip);
        chk(out_last == m_last && out_empty == m_empty, "R7 flags vs model",
            {out_last, out_empty}, {m_last, m_empty});
      end
      if (out_valid && out_ready) begin
        if (!out_empty) begin
          kept_cnt++;
          last_samp = out_samples;
          if (q_ids.size() > 0) begin
            int e;
            e = q_ids.pop_front();
            chk(int'(out_strip) == e, "R6 order", out_strip, e);
          end else chk(0, "R6 unexpected strip", out_strip, -1);
        end else mark_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic send(int id, int s0, int s1, int s2, int s3, int s4, int s5, bit last);
    bit r;
    @(posedge clk); #3;
    in_valid = 1; in_strip = 10'(id); in_last = last;
    in_samples = {12'(s5), 12'(s4), 12'(s3), 12'(s2), 12'(s1), 12'(s0)};
    do begin @(negedge clk); r = in_ready; @(posedge clk); end while (!r);
    #3 in_valid = 0; in_last = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic int fld(logic [77:0] v, int k);
    return int'($signed(v[k*13 +: 13]));
  endfunction

  initial begin
    int k0, m0, eb;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

    // R1/R2: baseline starts at 100
    send(1, 100, 150, 300, 220, 140, 110, 1); settle();
    chk(kept_cnt == 1, "R6 pulse kept", kept_cnt, 1);
    chk(fld(last_samp, 2) == 200, "R2 peak corrected", fld(last_samp, 2), 200);
    chk(fld(last_samp, 0) == 0, "R1 initial baseline", fld(last_samp, 0), 0);

    // R3 peak in first / sixth sample
    k0 = kept_cnt; m0 = mark_cnt;
    send(2, 300, 250, 200, 150, 120, 110, 0);
    send(3, 110, 120, 150, 200, 250, 300, 1); settle();
    chk(kept_cnt == k0, "R3 edge peaks dropped", kept_cnt, k0);
    chk(mark_cnt == m0 + 1, "R7 marker after dropped last", mark_cnt, m0 + 1);

    // R3 ties: earliest index wins
    k0 = kept_cnt;
    send(4, 250, 150, 250, 120, 100, 100, 0); settle();
    chk(kept_cnt == k0, "R3 tie at first sample dropped", kept_cnt, k0);
    send(5, 100, 250, 200, 250, 100, 100, 1); settle();
    chk(kept_cnt == k0 + 1, "R3 tie inside kept", kept_cnt, k0 + 1);
    chk(fld(last_samp, 1) == 150 && fld(last_samp, 3) == 150, "R2 tie values",
        fld(last_samp, 3), 150);

    // R4 threshold boundary
    k0 = kept_cnt;
    send(6, 100, 150, 200, 150, 100, 100, 0); settle();
    chk(kept_cnt == k0 + 1, "R4 equal to threshold kept", kept_cnt, k0 + 1);
    send(7, 100, 150, 199, 150, 100, 100, 1); settle();
    chk(kept_cnt == k0 + 1, "R4 below threshold dropped", kept_cnt, k0 + 1);

    // R5 baseline tracking (strip 7 already updated it)
    eb = 1600; eb = eb + ((((100 + 150 + 199 + 150) / 4) * 16 - eb) >>> 4);
    for (int i = 0; i < 40; i++) begin
      send(10 + i, 180, 180, 180, 180, 180, 180, i == 39);
      eb = eb + ((180 * 16 - eb) >>> 4);
    end
    send(60, 180, 230, 400, 300, 200, 180, 1); settle();
    chk(fld(last_samp, 2) == 400 - eb / 16, "R5 tracked baseline", fld(last_samp, 2), 400 - eb / 16);

    // R6/R8 random traffic under backpressure
    bp = 1;
    for (int i = 0; i < 300; i++) begin
      int b, a, p;
      b = 150 + $urandom % 60; a = $urandom % 300; p = $urandom % 6;
      send(100 + i, b + (p == 0 ? a : 0), b + (p == 1 ? a : a / 4), b + (p == 2 ? a : a / 3),
           b + (p == 3 ? a : a / 2), b + (p == 4 ? a : 0), b + (p == 5 ? a : 0), $urandom % 5 == 0);
    end
    bp = 0;
    settle();
    chk(q_ids.size() == 0, "R6 all kept strips delivered", q_ids.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule